// File: doc/BRIEF.md
# Zero-Cross Synchronized Gain Update Controller

This block decides which gain, in dB, drives the switch network of a programmable microphone amplifier, and when that value may change. A 6-bit gain code arrives from the control port together with a one-cycle load strobe. The block holds the code, translates it to dB, and moves the active gain to the new value. It does this either at once or, when zero-cross gating is enabled, at the next sign change of the input signal. If no sign change arrives, a timeout of 16 millisecond ticks forces the change.

A unity override input forces the active gain to 0 dB straight away. Codes loaded while the override is high are still held. Releasing the override counts as an ordinary gain change and follows the same immediate or zero-cross rule. The sign bit from the analog comparator is asynchronous, so it passes through a two-flop synchronizer. A crossing is any change of the synchronized bit from one cycle to the next. Two outputs report the update state: a level that shows a deferred change is waiting, and a one-cycle strobe for each cycle in which the active gain moves.

Top module: `gain_zc_ctrl`

## Requirements
- R1: Gain code 0 gives an active gain of 0 dB.
- R2: Gain codes 1 to 56 give an active gain of code + 9 dB. The active gain is therefore always 0 or between 10 and 65.
- R3: Gain codes 57 to 63 give 65 dB. Loading a code whose gain equals the active gain causes no step and no pending change.
- R4: While unity_force is high, gain_db reads 0 from the first clock edge after it rises. Codes loaded meanwhile are kept and take effect only after unity_force falls.
- R5: With zc_enable low and unity_force low, a code loaded on clock edge k drives gain_db from edge k+1.
- R6: With zc_enable high, a pending change waits for a sign crossing. A change of sign_in before edge k reaches gain_db at edge k+2: two synchronizer flops plus the compare against the previous sample.
- R7: With zc_enable high and no crossing, a pending change is applied on the 16th ms_tick sampled while it is pending.
- R8: A code loaded while a change is pending replaces the pending value and restarts the timeout count from zero.
- R9: Releasing unity_force with zc_enable high leaves gain_db at 0, pending, until a crossing or the timeout applies the held code.
- R10: change_pending is high exactly when zc_enable is high, unity_force is low and the requested gain differs from gain_db.
- R11: gain_step is high for one cycle after each edge on which gain_db changes, and low otherwise.
- R12: After a synchronous reset with rst_n low, gain_db is 0, the held code is 0, and change_pending and gain_step are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_in | input | 6 | Gain code from the control port |
| code_load | input | 1 | One-cycle strobe that latches code_in |
| unity_force | input | 1 | High forces 0 dB and holds off any other gain |
| zc_enable | input | 1 | High defers changes to a zero crossing |
| sign_in | input | 1 | Asynchronous sign of the input signal |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| gain_db | output | 7 | Active gain in dB |
| change_pending | output | 1 | A deferred change is waiting |
| gain_step | output | 1 | One-cycle strobe after each gain change |

## Verification
The assertions assume that ms_tick and code_load are single-cycle pulses, and that the control inputs change only between clock edges. The bench drives every input on the falling edge and pulses the strobes for one cycle only, so it stays inside these assumptions. Random phases space the sign toggles and ticks sparsely enough that both the crossing path and the timeout path are taken. Directed phases hold the sign constant so that the 16-tick boundary and the timeout restart can be observed exactly.

// File: rtl/gzc_pkg.sv
// Package gzc_pkg
// Holds the default widths and dB constants shared by the gain controller
// and the function that maps a gain code to dB.
// Assumes codes are unsigned and the mapping is linear with a ceiling.
package gzc_pkg;
    localparam int unsigned CODE_W_DEF   = 6;
    localparam int unsigned GAIN_W_DEF   = 7;
    localparam int unsigned OFFSET_DEF   = 9;
    localparam int unsigned CEIL_DEF     = 65;
    localparam int unsigned TIMEOUT_DEF  = 16;

    // Code 0 means unity; other codes add an offset and saturate at the ceiling.
    function automatic int unsigned db_of(input int unsigned code,
                                          input int unsigned offset,
                                          input int unsigned ceil_db);
        int unsigned sum;
        if (code == 0) return 0;
        sum = code + offset;
        return (sum > ceil_db) ? ceil_db : sum;
    endfunction
endpackage

// File: rtl/gzc_sign_sync.sv
// Module gzc_sign_sync
// Brings the asynchronous sign bit into the clock domain through a chain of
// STAGES flops and flags a crossing whenever the synchronized value differs
// from the one seen the cycle before.
// Assumes sign_in may change at any time; it adds no filtering of glitches.
module gzc_sign_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sign_in,
    output logic crossing
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // First synchronizer stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= sign_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    endgenerate

    // Keep the previous synchronized sample for the crossing compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign crossing = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/gzc_decode.sv
// Module gzc_decode
// Combinational map from the held gain code to the gain in dB.
// Assumes OFFSET_DB + 2**CODE_W - 1 fits in GAIN_W + 1 bits.
module gzc_decode
    import gzc_pkg::*;
#(
    parameter int unsigned CODE_W    = CODE_W_DEF,
    parameter int unsigned GAIN_W    = GAIN_W_DEF,
    parameter int unsigned OFFSET_DB = OFFSET_DEF,
    parameter int unsigned CEIL_DB   = CEIL_DEF
) (
    input  logic [CODE_W-1:0] code,
    output logic [GAIN_W-1:0] db
);
    // Translate the code through the shared mapping function.
    always_comb begin
        db = GAIN_W'(db_of(int'(code), OFFSET_DB, CEIL_DB));
    end
endmodule

// File: rtl/gzc_timeout.sv
// Module gzc_timeout
// Counts millisecond ticks while a change is pending and raises hit on the
// tick that completes LIMIT of them.
// Assumes the owner asserts restart whenever the count must start over.
module gzc_timeout #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic hit,
    output logic [$clog2(LIMIT+1)-1:0] count
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    // Advance on each tick while running; clear on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (run && tick)  cnt_q <= cnt_q + 1'b1;
    end

    assign hit   = run && tick && (cnt_q == CNT_W'(LIMIT - 1));
    assign count = cnt_q;
endmodule

// File: rtl/gain_zc_ctrl.sv
// Module gain_zc_ctrl
// Holds the gain code, derives the requested gain, and moves the active gain
// to it at once, at a zero crossing, or on timeout. The unity override wins
// at once.
// Assumes code_load and ms_tick are single-cycle pulses in this clock domain.
module gain_zc_ctrl
    import gzc_pkg::*;
#(
    parameter int unsigned CODE_W      = CODE_W_DEF,
    parameter int unsigned GAIN_W      = GAIN_W_DEF,
    parameter int unsigned OFFSET_DB   = OFFSET_DEF,
    parameter int unsigned CEIL_DB     = CEIL_DEF,
    parameter int unsigned TIMEOUT_MS  = TIMEOUT_DEF,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_load,
    input  logic              unity_force,
    input  logic              zc_enable,
    input  logic              sign_in,
    input  logic              ms_tick,
    output logic [GAIN_W-1:0] gain_db,
    output logic              change_pending,
    output logic              gain_step
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_MS + 1);

    logic [CODE_W-1:0] code_q;
    logic [GAIN_W-1:0] reg_db;
    logic [GAIN_W-1:0] want_db;
    logic [GAIN_W-1:0] active_q;
    logic              step_q;
    logic              zc_pulse;
    logic              tmo_hit;
    logic [CNT_W-1:0]  tmo_count;
    logic              differs;
    logic              pend_c;
    logic              take_now;
    logic              tmo_restart;

    // Hold the most recently loaded gain code.
    always_ff @(posedge clk) begin
        if (!rst_n)         code_q <= '0;
        else if (code_load) code_q <= code_in;
    end

    gzc_decode #(
        .CODE_W(CODE_W), .GAIN_W(GAIN_W),
        .OFFSET_DB(OFFSET_DB), .CEIL_DB(CEIL_DB)
    ) u_decode (
        .code(code_q),
        .db  (reg_db)
    );

    gzc_sign_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sign_in (sign_in),
        .crossing(zc_pulse)
    );

    // Requested gain and the decision whether it may be applied this cycle.
    always_comb begin
        want_db     = unity_force ? '0 : reg_db;
        differs     = (want_db != active_q);
        pend_c      = zc_enable && !unity_force && differs;
        take_now    = !unity_force && differs && (!zc_enable || zc_pulse || tmo_hit);
        tmo_restart = code_load || !pend_c || take_now;
    end

    gzc_timeout #(.LIMIT(TIMEOUT_MS)) u_timeout (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(tmo_restart),
        .run    (pend_c),
        .tick   (ms_tick),
        .hit    (tmo_hit),
        .count  (tmo_count)
    );

    // Update the active gain and mark each cycle in which it moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            step_q   <= 1'b0;
        end else if (unity_force) begin
            active_q <= '0;
            step_q   <= (active_q != '0);
        end else if (take_now) begin
            active_q <= want_db;
            step_q   <= 1'b1;
        end else begin
            step_q   <= 1'b0;
        end
    end

    assign gain_db        = active_q;
    assign change_pending = pend_c;
    assign gain_step      = step_q;
endmodule

// File: rtl/gzc_ctrl_checker.sv
// Module gzc_ctrl_checker
// Temporal properties of the gain controller, bound onto every instance.
// Assumes single-cycle strobes on the inputs, as stated in the brief.
module gzc_ctrl_checker #(
    parameter int unsigned GAIN_W     = 7,
    parameter int unsigned CEIL_DB    = 65,
    parameter int unsigned OFFSET_DB  = 9,
    parameter int unsigned TIMEOUT_MS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              unity_force,
    input logic              zc_enable,
    input logic [GAIN_W-1:0] gain_db,
    input logic              change_pending,
    input logic              gain_step,
    input logic              zc_pulse,
    input logic              tmo_hit,
    input logic [$clog2(TIMEOUT_MS+1)-1:0] tmo_count
);
    assert_gain_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_db == '0) || (gain_db > GAIN_W'(OFFSET_DB) && gain_db <= GAIN_W'(CEIL_DB)));

    assert_unity_forces_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unity_force |=> (gain_db == '0));

    assert_pending_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (change_pending && !zc_pulse && !tmo_hit) |=> $stable(gain_db));

    assert_crossing_applies_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (change_pending && zc_pulse) |=> gain_step);

    assert_timeout_applies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (change_pending && tmo_hit) |=> gain_step);

    assert_timeout_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_count < ($clog2(TIMEOUT_MS+1))'(TIMEOUT_MS));

    assert_pending_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
        change_pending |-> (zc_enable && !unity_force));

    assert_step_moves_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gain_step |-> (gain_db != $past(gain_db)));

    assert_quiet_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_step |-> $stable(gain_db));
endmodule

bind gain_zc_ctrl gzc_ctrl_checker #(
    .GAIN_W(GAIN_W), .CEIL_DB(CEIL_DB), .OFFSET_DB(OFFSET_DB), .TIMEOUT_MS(TIMEOUT_MS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .unity_force   (unity_force),
    .zc_enable     (zc_enable),
    .gain_db       (gain_db),
    .change_pending(change_pending),
    .gain_step     (gain_step),
    .zc_pulse      (zc_pulse),
    .tmo_hit       (tmo_hit),
    .tmo_count     (tmo_count)
);

// File: tb/gain_zc_ctrl_tb_top.sv
// Bench for gain_zc_ctrl: directed corner cases followed by seeded random
// stimulus, compared each cycle against a behavioural model built from the
// requirements.
module gain_zc_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  TMO        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] code_in = '0;
    logic       code_load = 1'b0;
    logic       unity_force = 1'b0;
    logic       zc_enable = 1'b0;
    logic       sign_in = 1'b0;
    logic       ms_tick = 1'b0;
    logic [6:0] gain_db;
    logic       change_pending;
    logic       gain_step;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gain_zc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .code_load(code_load),
        .unity_force(unity_force), .zc_enable(zc_enable), .sign_in(sign_in),
        .ms_tick(ms_tick), .gain_db(gain_db), .change_pending(change_pending),
        .gain_step(gain_step)
    );

    // Requirement mapping R1, R2, R3.
    function automatic int exp_db(input int c);
        if (c == 0)  return 0;
        if (c >= 57) return 65;
        return c + 9;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cycles);
        end
    endtask

    // Behavioural model of the requirements, advanced on each rising edge.
    int m_code = 0, m_act = 0, m_cnt = 0;
    bit m_s1 = 0, m_s2 = 0, m_s3 = 0, m_step = 0;
    always @(posedge clk) begin
        int  want;
        bit  pend, zc, apply;
        if (!rst_n) begin
            m_code = 0; m_act = 0; m_cnt = 0; m_step = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            want  = unity_force ? 0 : exp_db(m_code);
            zc    = (m_s2 != m_s3);
            pend  = zc_enable && !unity_force && (want != m_act);
            apply = !unity_force && (want != m_act) &&
                    (!zc_enable || zc || (pend && ms_tick && m_cnt == TMO-1));
            if (unity_force)  begin m_step = (m_act != 0); m_act = 0; end
            else if (apply)   begin m_step = 1; m_act = want; end
            else              m_step = 0;
            if (code_load || !pend || apply) m_cnt = 0;
            else if (ms_tick)                m_cnt = m_cnt + 1;
            if (code_load) m_code = int'(code_in);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = sign_in;
        end
    end

    // Model comparison away from the active edge (R5, R10, R11 every cycle).
    always @(negedge clk) begin
        int want;
        cycles++;
        if (rst_n) begin
            want = unity_force ? 0 : exp_db(m_code);
            chk(int'(gain_db) == m_act, "R5 model gain", int'(gain_db), m_act);
            chk(change_pending == (zc_enable && !unity_force && want != m_act),
                "R10 pending", int'(change_pending), int'(zc_enable && !unity_force && want != m_act));
            chk(gain_step == m_step, "R11 step", int'(gain_step), int'(m_step));
        end
    end

    task automatic load(input int c);
        @(negedge clk); code_in = 6'(c); code_load = 1'b1;
        @(negedge clk); code_load = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c0de));
        repeat (3) @(negedge clk);
        chk(gain_db == 0 && !change_pending && !gain_step, "R12 reset", int'(gain_db), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gain_db == 0, "R12 after reset", int'(gain_db), 0);

        // Immediate path, R5 and decode corners R1-style singles.
        load(1); @(negedge clk);
        chk(gain_db == 10, "R2 code 1", int'(gain_db), 10);
        chk(gain_step == 1, "R11 strobe", int'(gain_step), 1);
        @(negedge clk);
        chk(gain_step == 0, "R11 one cycle", int'(gain_step), 0);
        load(0); @(negedge clk);
        chk(gain_db == 0, "R1 code 0", int'(gain_db), 0);
        load(56); @(negedge clk);
        chk(gain_db == 65, "R2 code 56", int'(gain_db), 65);
        load(57); @(negedge clk);
        chk(gain_db == 65 && !gain_step, "R3 code 57 no step", int'(gain_db), 65);
        load(63); @(negedge clk);
        chk(gain_db == 65 && !change_pending, "R3 code 63", int'(gain_db), 65);

        // Override R4.
        @(negedge clk); unity_force = 1'b1;
        @(negedge clk);
        chk(gain_db == 0, "R4 forced unity", int'(gain_db), 0);
        load(30); repeat (3) @(negedge clk);
        chk(gain_db == 0, "R4 held under override", int'(gain_db), 0);
        unity_force = 1'b0;
        @(negedge clk);
        chk(gain_db == 39, "R4 applied after release", int'(gain_db), 39);

        // Zero-cross path R6.
        zc_enable = 1'b1;
        load(20);
        chk(change_pending == 1, "R10 pending raised", int'(change_pending), 1);
        repeat (5) @(negedge clk);
        chk(gain_db == 39, "R6 held without crossing", int'(gain_db), 39);
        sign_in = 1'b1;
        repeat (2) @(negedge clk);
        chk(gain_db == 39, "R6 not before sync", int'(gain_db), 39);
        @(negedge clk);
        chk(gain_db == 29, "R6 applied at crossing", int'(gain_db), 29);

        // Timeout R7.
        load(25);
        tick_n(TMO - 1);
        chk(gain_db == 29, "R7 before timeout", int'(gain_db), 29);
        tick_n(1);
        chk(gain_db == 34, "R7 timeout", int'(gain_db), 34);

        // Replacement and restart R8.
        load(40); tick_n(10);
        load(41); tick_n(TMO - 1);
        chk(gain_db == 34 && change_pending, "R8 restarted count", int'(gain_db), 34);
        tick_n(1);
        chk(gain_db == 50, "R8 newest code", int'(gain_db), 50);

        // Override release under zero-cross R9.
        @(negedge clk); unity_force = 1'b1;
        load(12);
        chk(gain_db == 0, "R9 forced", int'(gain_db), 0);
        unity_force = 1'b0;
        repeat (4) @(negedge clk);
        chk(gain_db == 0 && change_pending, "R9 release pending", int'(gain_db), 0);
        sign_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(gain_db == 21, "R9 release at crossing", int'(gain_db), 21);

        // Seeded random phase, checked against the model.
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            code_load = ($urandom_range(0, 19) == 0);
            case ($urandom_range(0, 4))
                0:       code_in = 6'($urandom_range(0, 1));
                1:       code_in = 6'($urandom_range(55, 58));
                2:       code_in = 6'd63;
                default: code_in = 6'($urandom_range(0, 63));
            endcase
            if ($urandom_range(0, 149) == 0) unity_force = ~unity_force;
            if ($urandom_range(0, 199) == 0) zc_enable = ~zc_enable;
            if ($urandom_range(0, 59) == 0)  sign_in = ~sign_in;
            ms_tick = ($urandom_range(0, 5) == 0);
        end
        @(negedge clk);
        code_load = 1'b0; ms_tick = 1'b0;
        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule